// File: doc/BRIEF.md
# Byte-Lane Zero-Minimizing Inversion Codec

This block reduces the number of low levels driven onto a byte-lane data bus whose drivers draw current only while a wire is low. It has two independent paths. The transmit path looks at each 8-bit lane of a beat. It inverts the whole lane when that lies low on most of its wires, and it sends one active-low flag per lane that records the choice. The receive path takes the lanes and their flags and restores the original bytes.

Each path is a single registered stage with a valid/ready handshake on both sides. A path accepts a beat when `*_in_valid` and `*_in_ready` are both high at a rising clock edge. `*_in_ready` is high whenever the output register is empty or the consumer is taking its beat in that cycle (`*_out_ready` high). A beat held back by a low `*_out_ready` stays on the outputs unchanged until it is taken. Without stalls, a beat appears one cycle after it is accepted. A global enable turns the coding off for both paths. The enable is sampled together with the beat.

Top module: `dbi_codec`

## Requirements
- R1: With the enable high, a transmit lane whose 8 data bits include 5 or more zeros is sent with all 8 bits inverted and its flag at 0.
- R2: With the enable high, a transmit lane with 4 or fewer zeros, including exactly 4, is sent unchanged with its flag at 1.
- R3: With the enable high, every encoded lane shows at least 5 ones across its 8 data wires and its flag.
- R4: Each lane decides from its own byte alone, with no effect from other lanes or from earlier beats. Lane k occupies data bits [8k+7:8k] and flag bit k.
- R5: With the enable high, the receive path inverts all 8 bits of a lane whose flag is 0 and passes the lane unchanged when its flag is 1.
- R6: With the enable low, transmit passes data unchanged with every flag at 1, and receive passes data unchanged whatever the flags are.
- R7: An accepted beat appears on the path's output with valid high on the next clock, and beats leave each path in the order they were accepted.
- R8: While an output holds valid high and its ready is low, that output's data and flags stay stable and the path's input ready is low.
- R9: A synchronous reset clears both output valids and sets all output data and all flags to 1.
- R10: Decoding the encoded form of any byte value, in any lane, returns the original byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Coding enable for both paths |
| tx_in_valid | input | 1 | Transmit beat offered |
| tx_in_ready | output | 1 | Transmit path can take a beat |
| tx_in_data | input | 8*LANES | Raw transmit bytes, lane k at [8k+7:8k] |
| tx_out_valid | output | 1 | Encoded beat present |
| tx_out_ready | input | 1 | Consumer takes the encoded beat |
| tx_out_data | output | 8*LANES | Encoded lane bits |
| tx_out_flag_n | output | LANES | Per-lane flag, 0 = lane inverted |
| rx_in_valid | input | 1 | Receive beat offered |
| rx_in_ready | output | 1 | Receive path can take a beat |
| rx_in_data | input | 8*LANES | Received lane bits |
| rx_in_flag_n | input | LANES | Received per-lane flags, 0 = inverted |
| rx_out_valid | output | 1 | Restored beat present |
| rx_out_ready | input | 1 | Consumer takes the restored beat |
| rx_out_data | output | 8*LANES | Restored bytes |

## Verification
The bench aims at the threshold of exactly four zeros. A design that used "four or more" there would invert and drop to four highs, and one that used "more than five" would leave five-zero lanes uninverted. It mixes inverting and non-inverting lanes in one beat to catch a decision shared across lanes or a swapped lane order. It also drives receive flags of 0 with the enable low, which must be ignored. Stalls under random ready expose a register that overwrites or drops a held beat. A loopback pass over all 256 byte values in every lane catches a polarity error that only one of the two paths makes.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  localparam int BYTE_W = 8;
  // zeros needed in a lane before inversion pays off
  localparam int INV_THRESH = BYTE_W / 2 + 1;
  localparam int CNT_W = $clog2(BYTE_W + 1);
endpackage

// File: rtl/dbi_lane_enc.sv
module dbi_lane_enc
  import dbi_pkg::*;
(
  input  logic              en,
  input  logic [BYTE_W-1:0] raw,
  output logic [BYTE_W-1:0] coded,
  output logic              flag_n
);
  logic [CNT_W-1:0] zeros;
  logic             flip;

  always_comb begin
    zeros = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      zeros = zeros + CNT_W'(~raw[i]);
    end
  end

  assign flip   = en && (zeros >= CNT_W'(INV_THRESH));
  assign coded  = flip ? ~raw : raw;
  assign flag_n = ~flip;
endmodule

// File: rtl/dbi_lane_dec.sv
module dbi_lane_dec
  import dbi_pkg::*;
(
  input  logic              en,
  input  logic [BYTE_W-1:0] coded,
  input  logic              flag_n,
  output logic [BYTE_W-1:0] raw
);
  logic flip;

  assign flip = en && !flag_n;
  assign raw  = flip ? ~coded : coded;
endmodule

// File: rtl/dbi_pipe_reg.sv
module dbi_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '1;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= in_data;
      end
    end
  end
endmodule

// File: rtl/dbi_codec.sv
module dbi_codec
  import dbi_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    tx_in_valid,
  output logic                    tx_in_ready,
  input  logic [LANES*BYTE_W-1:0] tx_in_data,
  output logic                    tx_out_valid,
  input  logic                    tx_out_ready,
  output logic [LANES*BYTE_W-1:0] tx_out_data,
  output logic [LANES-1:0]        tx_out_flag_n,
  input  logic                    rx_in_valid,
  output logic                    rx_in_ready,
  input  logic [LANES*BYTE_W-1:0] rx_in_data,
  input  logic [LANES-1:0]        rx_in_flag_n,
  output logic                    rx_out_valid,
  input  logic                    rx_out_ready,
  output logic [LANES*BYTE_W-1:0] rx_out_data
);
  localparam int DW    = LANES * BYTE_W;
  localparam int TX_W  = DW + LANES;

  logic [DW-1:0]    enc_data;
  logic [LANES-1:0] enc_flag_n;
  logic [DW-1:0]    dec_data;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    dbi_lane_enc u_enc (
      .en     (en),
      .raw    (tx_in_data[k*BYTE_W +: BYTE_W]),
      .coded  (enc_data[k*BYTE_W +: BYTE_W]),
      .flag_n (enc_flag_n[k])
    );
    dbi_lane_dec u_dec (
      .en     (en),
      .coded  (rx_in_data[k*BYTE_W +: BYTE_W]),
      .flag_n (rx_in_flag_n[k]),
      .raw    (dec_data[k*BYTE_W +: BYTE_W])
    );
  end

  dbi_pipe_reg #(.W(TX_W)) u_tx_reg (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (tx_in_valid),
    .in_ready  (tx_in_ready),
    .in_data   ({enc_flag_n, enc_data}),
    .out_valid (tx_out_valid),
    .out_ready (tx_out_ready),
    .out_data  ({tx_out_flag_n, tx_out_data})
  );

  dbi_pipe_reg #(.W(DW)) u_rx_reg (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (rx_in_valid),
    .in_ready  (rx_in_ready),
    .in_data   (dec_data),
    .out_valid (rx_out_valid),
    .out_ready (rx_out_ready),
    .out_data  (rx_out_data)
  );
endmodule

// File: rtl/dbi_codec_chk.sv
module dbi_codec_chk #(
  parameter int LANES = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 en,
  input logic                 tx_in_valid,
  input logic                 tx_in_ready,
  input logic [LANES*8-1:0]   tx_in_data,
  input logic                 tx_out_valid,
  input logic                 tx_out_ready,
  input logic [LANES*8-1:0]   tx_out_data,
  input logic [LANES-1:0]     tx_out_flag_n,
  input logic                 rx_in_valid,
  input logic                 rx_in_ready,
  input logic [LANES*8-1:0]   rx_in_data,
  input logic [LANES-1:0]     rx_in_flag_n,
  input logic                 rx_out_valid,
  input logic                 rx_out_ready,
  input logic [LANES*8-1:0]   rx_out_data
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
    p_min_ones_r3: assert property (@(posedge clk) disable iff (rst)
      (tx_in_valid && tx_in_ready && en) |=>
        ($countones({tx_out_flag_n[k], tx_out_data[k*8 +: 8]}) >= 5));

    p_rx_flip_r5: assert property (@(posedge clk) disable iff (rst)
      (rx_in_valid && rx_in_ready && en && !rx_in_flag_n[k]) |=>
        (rx_out_data[k*8 +: 8] == ~$past(rx_in_data[k*8 +: 8])));
  end

  p_off_flags_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_in_valid && tx_in_ready && !en) |=>
      ((&tx_out_flag_n) && tx_out_data == $past(tx_in_data)));

  p_off_rx_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_in_valid && rx_in_ready && !en) |=> (rx_out_data == $past(rx_in_data)));

  p_tx_latency_r7: assert property (@(posedge clk) disable iff (rst)
    (tx_in_valid && tx_in_ready) |=> tx_out_valid);

  p_rx_latency_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_in_valid && rx_in_ready) |=> rx_out_valid);

  p_tx_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (tx_out_valid && !tx_out_ready) |=>
      (tx_out_valid && $stable(tx_out_data) && $stable(tx_out_flag_n)));

  p_rx_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_out_valid && !rx_out_ready) |=> (rx_out_valid && $stable(rx_out_data)));

  p_tx_block_r8: assert property (@(posedge clk) disable iff (rst)
    (tx_out_valid && !tx_out_ready) |-> !tx_in_ready);

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (!tx_out_valid && !rx_out_valid && (&tx_out_flag_n)
             && (&tx_out_data) && (&rx_out_data)));
endmodule

bind dbi_codec dbi_codec_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .en(en),
  .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
  .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
  .tx_out_data(tx_out_data), .tx_out_flag_n(tx_out_flag_n),
  .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
  .rx_in_flag_n(rx_in_flag_n), .rx_out_valid(rx_out_valid),
  .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data)
);

// File: tb/dbi_codec_tb.sv
module dbi_codec_tb;
  localparam int LANES = 4;
  localparam int N = LANES * 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1;
  logic tx_in_valid = 1'b0;
  logic [N-1:0] tx_in_data = '0;
  logic tx_rdy_drv = 1'b1;
  logic rx_drv_valid = 1'b0;
  logic [N-1:0] rx_drv_data = '0;
  logic [LANES-1:0] rx_drv_flag = '1;
  logic rx_out_ready = 1'b1;
  logic loopback = 1'b0;
  logic rand_ready = 1'b0;

  logic tx_in_ready, tx_out_valid, tx_out_ready;
  logic [N-1:0] tx_out_data;
  logic [LANES-1:0] tx_out_flag_n;
  logic rx_in_valid, rx_in_ready, rx_out_valid;
  logic [N-1:0] rx_in_data, rx_out_data;
  logic [LANES-1:0] rx_in_flag_n;

  int total = 0;
  int bad = 0;
  string phase = "R9";

  assign tx_out_ready = loopback ? rx_in_ready : tx_rdy_drv;
  assign rx_in_valid  = loopback ? tx_out_valid : rx_drv_valid;
  assign rx_in_data   = loopback ? tx_out_data : rx_drv_data;
  assign rx_in_flag_n = loopback ? tx_out_flag_n : rx_drv_flag;

  always #5 clk = ~clk;

  dbi_codec #(.LANES(LANES)) u_dut (
    .clk(clk), .rst(rst), .en(en),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
    .tx_out_data(tx_out_data), .tx_out_flag_n(tx_out_flag_n),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
    .rx_in_flag_n(rx_in_flag_n), .rx_out_valid(rx_out_valid),
    .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data)
  );

  // behavioural coding rules
  function automatic logic [N+LANES-1:0] enc_beat(logic [N-1:0] d, logic on);
    logic [N-1:0] o;
    logic [LANES-1:0] f;
    for (int k = 0; k < LANES; k++) begin
      logic [7:0] b;
      b = d[k*8 +: 8];
      if (on && (8 - $countones(b)) >= 5) begin
        o[k*8 +: 8] = ~b;
        f[k] = 1'b0;
      end else begin
        o[k*8 +: 8] = b;
        f[k] = 1'b1;
      end
    end
    return {f, o};
  endfunction

  function automatic logic [N-1:0] dec_beat(logic [N-1:0] d, logic [LANES-1:0] f,
                                            logic on);
    logic [N-1:0] o;
    for (int k = 0; k < LANES; k++) begin
      o[k*8 +: 8] = (on && !f[k]) ? ~d[k*8 +: 8] : d[k*8 +: 8];
    end
    return o;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // cycle-level reference of both output registers
  logic m_tx_v, m_rx_v;
  logic [N-1:0] m_tx_d, m_rx_d;
  logic [LANES-1:0] m_tx_f;

  always @(posedge clk) begin
    if (rst) begin
      m_tx_v <= 1'b0; m_tx_d <= '1; m_tx_f <= '1;
      m_rx_v <= 1'b0; m_rx_d <= '1;
    end else begin
      if (!m_tx_v || tx_out_ready) begin
        m_tx_v <= tx_in_valid;
        if (tx_in_valid) {m_tx_f, m_tx_d} <= enc_beat(tx_in_data, en);
      end
      if (!m_rx_v || rx_out_ready) begin
        m_rx_v <= rx_in_valid;
        if (rx_in_valid) m_rx_d <= dec_beat(rx_in_data, rx_in_flag_n, en);
      end
    end
  end

  always @(negedge clk) begin
    if (rand_ready) begin
      rx_out_ready <= ($urandom % 4) != 0;
      if (!loopback) tx_rdy_drv <= ($urandom % 3) != 0;
    end
  end

  logic [N-1:0] sent_q[$];

  always @(negedge clk) begin
    #2;
    if (!rst) begin
      chk({phase, " tx valid"}, 64'(tx_out_valid), 64'(m_tx_v));
      chk({phase, " tx ready"}, 64'(tx_in_ready), 64'(!m_tx_v || tx_out_ready));
      chk({phase, " rx valid"}, 64'(rx_out_valid), 64'(m_rx_v));
      chk({phase, " rx ready"}, 64'(rx_in_ready), 64'(!m_rx_v || rx_out_ready));
      if (m_tx_v) chk({phase, " tx data/flag"}, 64'({tx_out_flag_n, tx_out_data}),
                      64'({m_tx_f, m_tx_d}));
      if (m_rx_v) chk({phase, " rx data"}, 64'(rx_out_data), 64'(m_rx_d));
      if (loopback) begin
        if (tx_out_valid && en) begin
          for (int k = 0; k < LANES; k++) begin
            chk("R3 ones>=5", 64'($countones({tx_out_flag_n[k], tx_out_data[k*8 +: 8]}) >= 5),
                64'd1);
          end
        end
        if (tx_in_valid && tx_in_ready) sent_q.push_back(tx_in_data);
        if (rx_out_valid && rx_out_ready) begin
          if (sent_q.size() == 0) chk("R10 extra beat", 64'd1, 64'd0);
          else chk("R10 round trip", 64'(rx_out_data), 64'(sent_q.pop_front()));
        end
      end
    end
  end

  task automatic push_tx(logic [N-1:0] d);
    tx_in_valid = 1'b1;
    tx_in_data  = d;
    #1;
    while (!tx_in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    tx_in_valid = 1'b0;
  endtask

  task automatic push_rx(logic [N-1:0] d, logic [LANES-1:0] f);
    rx_drv_valid = 1'b1;
    rx_drv_data  = d;
    rx_drv_flag  = f;
    #1;
    while (!rx_in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    rx_drv_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R9 tx valid", 64'(tx_out_valid), 64'd0);
    chk("R9 rx valid", 64'(rx_out_valid), 64'd0);
    chk("R9 tx data/flag", 64'({tx_out_flag_n, tx_out_data}), 64'({(N+LANES){1'b1}}));
    chk("R9 rx data", 64'(rx_out_data), 64'({N{1'b1}}));
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // lanes 3..0 = 00, 0F, FF, 07
    phase = "R1";
    push_tx(32'h000FFF07);
    #2;
    chk("R1 lane3 inverted", 64'(tx_out_data[31:24]), 64'hFF);
    chk("R1 lane0 inverted", 64'(tx_out_data[7:0]), 64'hF8);
    chk("R2 lane2 four zeros kept", 64'(tx_out_data[23:16]), 64'h0F);
    chk("R4 flags per lane", 64'(tx_out_flag_n), 64'h6);
    chk("R4 whole beat", 64'(tx_out_data), 64'hFF0FFFF8);
    @(negedge clk);

    phase = "R5";
    push_rx(32'h12345678, 4'b1010);
    #2;
    chk("R5 decode", 64'(rx_out_data), 64'h12CB5687);
    @(negedge clk);

    phase = "R6";
    en = 1'b0;
    push_tx(32'h00000000);
    #2;
    chk("R6 tx passthrough", 64'(tx_out_data), 64'h0);
    chk("R6 tx flags high", 64'(tx_out_flag_n), 64'hF);
    @(negedge clk);
    push_rx(32'h00FF0F81, 4'b0000);
    #2;
    chk("R6 rx flags ignored", 64'(rx_out_data), 64'h00FF0F81);
    @(negedge clk);
    en = 1'b1;

    phase = "R8";
    tx_rdy_drv = 1'b0;
    push_tx(32'h01020304);
    tx_in_valid = 1'b1;
    tx_in_data  = 32'hA5A5A5A5;
    repeat (3) @(negedge clk);
    #2;
    chk("R8 held data", 64'(tx_out_data), 64'(enc_beat(32'h01020304, 1'b1) & {N{1'b1}}));
    chk("R8 input blocked", 64'(tx_in_ready), 64'd0);
    @(negedge clk);
    tx_rdy_drv = 1'b1;
    @(negedge clk);
    tx_in_valid = 1'b0;
    @(negedge clk);
    #2;
    chk("R7 second beat follows", 64'(tx_out_data),
        64'(enc_beat(32'hA5A5A5A5, 1'b1) & {N{1'b1}}));
    @(negedge clk);

    phase = "R7";
    rand_ready = 1'b1;
    for (int i = 0; i < 300; i++) begin
      en = ($urandom % 5) != 0;
      tx_in_valid = $urandom % 2;
      tx_in_data = $urandom;
      rx_drv_valid = $urandom % 2;
      rx_drv_data = $urandom;
      rx_drv_flag = $urandom;
      @(negedge clk);
    end
    tx_in_valid = 1'b0;
    rx_drv_valid = 1'b0;
    en = 1'b1;
    rand_ready = 1'b0;
    tx_rdy_drv = 1'b1;
    rx_out_ready = 1'b1;
    repeat (4) @(negedge clk);

    phase = "R10";
    loopback = 1'b1;
    rand_ready = 1'b1;
    for (int i = 0; i < 256; i++) begin
      logic [N-1:0] beat;
      for (int k = 0; k < LANES; k++) beat[k*8 +: 8] = 8'((i + 64 * k) & 255);
      push_tx(beat);
    end
    rand_ready = 1'b0;
    rx_out_ready = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 all beats returned", 64'(sent_q.size()), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule